// File: doc/BRIEF.md
# Quarter-Rate Interval Timer with Spliced Compare

The block keeps a free-running 64-bit counter that advances once per clock. Software sees a tick count running at one quarter of that rate: the counter with its two least significant bits dropped. A 32-bit compare value is written through a strobe. The block scales it by four and merges it into the low 34 bits of the present counter value to form a full 64-bit deadline.

A deadline that lands in the past, or less than a guard distance ahead, is pushed one full 2^34-count period into the future. This gives a narrow compare register an unambiguous meaning against a wide counter.

When the counter equals the deadline, a level interrupt is raised. It stays high until it is acknowledged or until a fresh compare value is written. Crossing into other clock domains and interrupt routing are left to the surrounding logic.

Top module: `itv_timer`

## Requirements
- R1: After a synchronous reset the full-rate counter is 0. It then increases by exactly 1 on every clock edge and wraps modulo 2^64.
- R2: `tick_count` always equals the full-rate counter shifted right by two bits, so it advances by at most 1 per clock.
- R3: Reset loads the deadline with all ones and clears `irq`. With no compare write, `irq` stays low.
- R4: A write of value V while the counter holds C loads a candidate deadline on the next edge. The candidate keeps bits 63..34 of C and puts V in bits 33..2, with bits 1..0 zero. With no write, the deadline holds its value.
- R5: If the candidate is below C + 1000 (unsigned), 2^34 is added to it before it is stored.
- R6: `irq` rises on the clock edge after one where the counter equals the deadline, and at no other time.
- R7: Once high, `irq` stays high until `irq_ack` is sampled high, and it is low on the edge after the acknowledge.
- R8: A compare write forces `irq` low on the next edge, even if the counter matched the deadline on that same edge.
- R9: An `irq_ack` while `irq` is low changes neither `irq` nor the deadline. An acknowledge on the same edge as a match loses to the match, so `irq` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_wr | input | 1 | Strobe: load a new compare value this cycle |
| cmp_val | input | 32 | Compare value in quarter-rate ticks |
| irq_ack | input | 1 | Acknowledge; clears a pending interrupt |
| tick_count | output | 64 | Full-rate counter divided by four |
| deadline | output | 64 | Stored full-rate deadline |
| irq | output | 1 | Level interrupt; high after the counter meets the deadline |

## Verification
On every cycle, the assertions check:
- the counter steps by one;
- the tick count advances by at most one;
- the deadline stays still unless written, and after a write lies between 1 and 2^34+999 counts ahead of the counter;
- `irq` rises only after a match, is held until acknowledged, and falls after a write.

The bench's scenarios cover the rest:
- the exact splice of the written value into the deadline;
- the placement of the guard boundary, probed at both sides of the threshold;
- that an idle acknowledge has no effect;
- that a match beats a same-cycle acknowledge.

// File: rtl/itv_pkg.sv
package itv_pkg;
  localparam int ITV_CNT_W = 64;
  localparam int ITV_CMP_W = 32;
  localparam int ITV_SCALE_SH = 2;
  localparam int ITV_GUARD = 1000;

  typedef enum logic [1:0] {
    IRQ_EV_HOLD  = 2'd0,
    IRQ_EV_SET   = 2'd1,
    IRQ_EV_CLEAR = 2'd2
  } irq_ev_e;
endpackage

// File: rtl/itv_counter.sv
module itv_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/itv_deadline.sv
module itv_deadline #(
  parameter int CNT_W    = 64,
  parameter int CMP_W    = 32,
  parameter int SCALE_SH = 2,
  parameter int GUARD    = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CMP_W-1:0] val,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] deadline_q
);
  localparam int SPLICE_W = CMP_W + SCALE_SH;
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] PERIOD  = ONE << SPLICE_W;
  localparam logic [CNT_W-1:0] LOWMASK = PERIOD - ONE;
  localparam logic [CNT_W-1:0] GUARD_V = CNT_W'(GUARD);

  logic [CNT_W-1:0] scaled;
  logic [CNT_W-1:0] cand;
  logic [CNT_W-1:0] limit;
  logic             too_near;
  logic [CNT_W-1:0] next_dl;

  always_comb begin
    scaled   = CNT_W'(val) << SCALE_SH;
    cand     = (cnt & ~LOWMASK) | scaled;
    limit    = cnt + GUARD_V;
    too_near = cand < limit;
    next_dl  = too_near ? cand + PERIOD : cand;
  end

  always_ff @(posedge clk) begin
    if (rst)     deadline_q <= '1;
    else if (wr) deadline_q <= next_dl;
  end
endmodule

// File: rtl/itv_irq.sv
module itv_irq
  import itv_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] deadline,
  input  logic             wr,
  input  logic             ack,
  output logic             irq_q
);
  logic    hit;
  irq_ev_e ev;

  always_comb begin
    hit = (cnt == deadline);
    if (wr)       ev = IRQ_EV_CLEAR;
    else if (hit) ev = IRQ_EV_SET;
    else if (ack) ev = IRQ_EV_CLEAR;
    else          ev = IRQ_EV_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else begin
      case (ev)
        IRQ_EV_SET:   irq_q <= 1'b1;
        IRQ_EV_CLEAR: irq_q <= 1'b0;
        default:      irq_q <= irq_q;
      endcase
    end
  end
endmodule

// File: rtl/itv_timer.sv
module itv_timer
  import itv_pkg::*;
#(
  parameter int CNT_W    = ITV_CNT_W,
  parameter int CMP_W    = ITV_CMP_W,
  parameter int SCALE_SH = ITV_SCALE_SH,
  parameter int GUARD    = ITV_GUARD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_wr,
  input  logic [CMP_W-1:0] cmp_val,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] tick_count,
  output logic [CNT_W-1:0] deadline,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;

  itv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .cnt_q (cnt)
  );

  itv_deadline #(
    .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_SH(SCALE_SH), .GUARD(GUARD)
  ) u_dl (
    .clk        (clk),
    .rst        (rst),
    .wr         (cmp_wr),
    .val        (cmp_val),
    .cnt        (cnt),
    .deadline_q (deadline)
  );

  itv_irq #(.CNT_W(CNT_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt),
    .deadline (deadline),
    .wr       (cmp_wr),
    .ack      (irq_ack),
    .irq_q    (irq)
  );

  assign tick_count = {{SCALE_SH{1'b0}}, cnt[CNT_W-1:SCALE_SH]};
endmodule

// File: rtl/itv_timer_chk.sv
module itv_timer_chk #(
  parameter int CNT_W    = 64,
  parameter int CMP_W    = 32,
  parameter int SCALE_SH = 2,
  parameter int GUARD    = 1000
) (
  input logic             clk,
  input logic             rst,
  input logic             cmp_wr,
  input logic             irq_ack,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tick_count,
  input logic [CNT_W-1:0] deadline,
  input logic             irq
);
  localparam logic [CNT_W-1:0] ONE    = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] SPAN   = (ONE << (CMP_W + SCALE_SH)) + CNT_W'(GUARD);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == $past(cnt) + ONE); // R1

  AST_TICK_RATE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tick_count == $past(tick_count)) || (tick_count == $past(tick_count) + ONE)); // R2

  AST_DL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmp_wr |=> $stable(deadline)); // R4

  AST_DL_AHEAD: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> ((deadline - $past(cnt)) != '0) && ((deadline - $past(cnt)) < SPAN)); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !irq ##1 irq |-> $past(cnt) == $past(deadline)); // R6

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack && !cmp_wr) |=> irq); // R7

  AST_WR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> !irq); // R8
endmodule

bind itv_timer itv_timer_chk #(
  .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_SH(SCALE_SH), .GUARD(GUARD)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmp_wr     (cmp_wr),
  .irq_ack    (irq_ack),
  .cnt        (cnt),
  .tick_count (tick_count),
  .deadline   (deadline),
  .irq        (irq)
);

// File: tb/tb_itv_timer.sv
`timescale 1ns/1ps
module tb_itv_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_wr = 1'b0;
  logic [31:0] cmp_val = '0;
  logic        irq_ack = 1'b0;
  logic [63:0] tick_count;
  logic [63:0] deadline;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  itv_timer dut (
    .clk(clk), .rst(rst), .cmp_wr(cmp_wr), .cmp_val(cmp_val),
    .irq_ack(irq_ack), .tick_count(tick_count), .deadline(deadline), .irq(irq)
  );

  // reference full-rate count, from R1
  logic [63:0] mcnt = '0;
  always @(posedge clk) mcnt <= rst ? 64'd0 : mcnt + 64'd1;

  function automatic logic [63:0] ref_dl(input logic [63:0] c, input logic [31:0] v);
    logic [63:0] b;
    b = {c[63:34], v, 2'b00};
    if (b < c + 64'd1000) b = b + (64'd1 << 34);
    return b;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic        wr_seen = 1'b0;
  always @(posedge clk) wr_seen <= cmp_wr;
  always @(negedge clk) begin
    if (wr_seen && exp_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(deadline == e, t, deadline, e);
    end
  end

  task automatic do_write(input logic [31:0] v, input string tag);
    cmp_wr = 1'b1;
    cmp_val = v;
    exp_q.push_back(ref_dl(mcnt, v));
    tag_q.push_back(tag);
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic wait_match(input logic [63:0] dl);
    while (mcnt != dl) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [63:0] dl;
    logic [31:0] v;
    repeat (4) @(negedge clk);
    check(deadline == '1, "R3 reset deadline", deadline, '1);
    check(irq == 1'b0, "R3 reset irq", {63'd0, irq}, 64'd0);
    check(tick_count == 64'd0, "R1 reset count", tick_count, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(tick_count == 64'd0, "R1 first step", tick_count, 64'd0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(tick_count == (mcnt >> 2), "R2 quarter rate", tick_count, mcnt >> 2);
    end
    check(irq == 1'b0, "R3 no irq without write", {63'd0, irq}, 64'd0);

    // R4 far value, R5 near value, R5 threshold both sides
    do_write(32'd1000, "R4 splice far");
    @(negedge clk);
    do_write(32'd10, "R5 advance past value");
    @(negedge clk);
    v = 32'((mcnt + 64'd1000) >> 2);
    do_write(v - 32'd1, "R5 below guard");
    v = 32'((mcnt + 64'd1000 + 64'd3) >> 2);
    do_write(v + 32'd1, "R5 above guard");
    @(negedge clk);
    check(exp_q.size() == 0, "R4 scoreboard drained", 64'(exp_q.size()), 64'd0);

    // R9 idle ack
    dl = deadline;
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq == 1'b0, "R9 idle ack irq", {63'd0, irq}, 64'd0);
    check(deadline == dl, "R9 idle ack deadline", deadline, dl);

    // R6 / R7: reach deadline, hold, acknowledge
    v = 32'((mcnt + 64'd1200) >> 2);
    do_write(v, "R4 target");
    dl = {30'd0, v, 2'b00};
    wait_match(dl);
    check(irq == 1'b0, "R6 low at match", {63'd0, irq}, 64'd0);
    @(negedge clk);
    check(irq == 1'b1, "R6 rise after match", {63'd0, irq}, 64'd1);
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R7 held", {63'd0, irq}, 64'd1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq == 1'b0, "R7 cleared by ack", {63'd0, irq}, 64'd0);
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R6 no second rise", {63'd0, irq}, 64'd0);

    // R8: write clears a pending irq
    v = 32'((mcnt + 64'd1100) >> 2);
    do_write(v, "R4 target two");
    dl = {30'd0, v, 2'b00};
    wait_match(dl);
    @(negedge clk);
    check(irq == 1'b1, "R6 second rise", {63'd0, irq}, 64'd1);
    do_write(32'd5, "R5 write during irq");
    check(irq == 1'b0, "R8 write clears", {63'd0, irq}, 64'd0);

    // R8: write on the match cycle wins
    v = 32'((mcnt + 64'd1100) >> 2);
    do_write(v, "R4 target three");
    dl = {30'd0, v, 2'b00};
    wait_match(dl);
    do_write(32'd7, "R5 write at match");
    check(irq == 1'b0, "R8 write beats match", {63'd0, irq}, 64'd0);

    // R9: ack on the match cycle loses
    v = 32'((mcnt + 64'd1100) >> 2);
    do_write(v, "R4 target four");
    dl = {30'd0, v, 2'b00};
    wait_match(dl);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq == 1'b1, "R9 match beats ack", {63'd0, irq}, 64'd1);
    @(negedge clk);
    check(tick_count == (mcnt >> 2), "R2 late quarter rate", tick_count, mcnt >> 2);
    finish_run();
  end
endmodule